// File: doc/BRIEF.md
# Write-masked banked control register file

This block holds the system control registers of a multithreaded core. Each register sits at a flat index formed from a 5-bit register number and a 3-bit select, so the index is the register number times eight plus the select. Each register has a write mask fixed at reset. Software writes change only the writable bits and leave the read-only bits at their current value. A second, privileged write port lets hardware load any value and ignores the mask.

Registers come in three storage classes. Shared registers have one copy. Per-thread registers have one copy for each thread context, chosen directly by the requesting thread ID. Per-virtual-processor registers have one copy for each virtual processor. For these, the bank is the virtual-processor number held in the binding register of the requesting thread. Reads are combinational.

Top module: `cp_ctrl_regfile`

## Requirements
- R1: The flat index is {reg[4:0], sel[2:0]} (reg*8+sel). The implemented indices are:
  - shared: 0, 8, 16, 24, 32, 40, 41, 64, 97, 98, 104, 120, 128–131
  - per thread: 96, 17–23, 136, 184
  - per virtual processor: 9–15, 49–53, 121
- R2: A software write stores (data & mask) | (old & ~mask). For the core status register (index 96) the mask is 0xFF78FF17.
- R3: Per-thread registers are selected by the thread ID of the access. A write through one thread never changes another thread's copy.
- R4: Per-virtual-processor registers are selected by bits [VP_W-1:0] of the requesting thread's binding register (index 18, bank field in bits [3:0]). A bank value of NUM_VPROC or more selects bank 0. The binding register resets to (thread << 21) and is fully writable.
- R5: The core status register resets to 0x00400004 in every thread.
- R6: These registers are fully read-only to software:
  - index 8 (resets to 63)
  - 120 (PROC_ID)
  - 129 (CFG1_INIT)
  - 131 (CFG3_INIT)
  - 64 and 136 (reset 0)
- R7: Write masks and reset values are:
  | Index | Write mask | Reset value |
  |---|---|---|
  | 0 | 0x7FFFFFFF | 0 |
  | 16 | 0x3FFFFFFF | 0 |
  | 24 | 0x3FFFFFFF | 0 |
  | 32 | 0xFF800000 | 0 |
  | 40 | 0x1FFFF800 | 0 |
  | 41 | 0x10000000 | 0 |
  | 97 | 0x000003E0 | 0 |
  | 98 | 0x0000F3C0 | 0 |
  | 104 | 0x08C00300 | 0 |
  | 121 | 0x3FFFF000 | see R12 |
  | 128 | 0x7FFF0007 | CFG0_INIT with bit 31 set |
  | 130 | 0x7000F000 | CFG2_INIT |
- R8: Every other implemented register resets to 0 (except as R4 and R13 say) and has an all-ones write mask.
- R9: A direct write stores its data unmasked, including into read-only registers. When both ports hit the same copy in one cycle, the direct write wins.
- R10: A write of either kind to an unimplemented index changes nothing, and a read of one returns 0.
- R11: Read data reflects the addressed copy in the same cycle, with no clock edge between address and data.
- R12: The exception-base register (index 121) of virtual processor v resets to 0x80000000 | v.
- R13: The thread-status register (index 17) resets to 0x00002000 for thread 0 and to 0x00008000 for every other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_tid | input | TID_W (2) | Thread issuing the read |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data, combinational |
| sw_we | input | 1 | Masked software write enable |
| sw_tid | input | TID_W (2) | Thread issuing the software write |
| sw_reg | input | 5 | Software write register number |
| sw_sel | input | 3 | Software write select |
| sw_data | input | 32 | Software write data |
| hw_we | input | 1 | Unmasked direct write enable |
| hw_tid | input | TID_W (2) | Thread on whose behalf the direct write is made |
| hw_reg | input | 5 | Direct write register number |
| hw_sel | input | 3 | Direct write select |
| hw_data | input | 32 | Direct write data |

## Verification
The assertions check on every cycle that:
- the core status register follows the masked-write formula in each thread;
- each thread's copy stays stable unless that thread writes it;
- the random-count and identity registers move only under a direct write, which they then take unmasked;
- an unimplemented index reads zero.

Only the bench scenarios can show the rest:
- the full set of reset values and write masks;
- the rebinding of a thread to another virtual processor, and the bank change it causes;
- port priority when both writes collide.

// File: rtl/crf_pkg.sv
// Shared types, index map and write masks of the control register file.
// Assumes a 32-bit register width; indices are {reg, sel}.
package crf_pkg;

    localparam int XLEN   = 32;
    localparam int SLOT_W = 4;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [7:0]      flat_t;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_SHARED = 2'd1,
        K_THREAD = 2'd2,
        K_VPROC  = 2'd3
    } kind_e;

    // Shared registers
    localparam flat_t IX_TLB_INDEX  = 8'd0;
    localparam flat_t IX_RAND       = 8'd8;
    localparam flat_t IX_TLB_LO0    = 8'd16;
    localparam flat_t IX_TLB_LO1    = 8'd24;
    localparam flat_t IX_PTE_CTX    = 8'd32;
    localparam flat_t IX_PG_MASK    = 8'd40;
    localparam flat_t IX_PG_GRAIN   = 8'd41;
    localparam flat_t IX_FAULT_VA   = 8'd64;
    localparam flat_t IX_IRQ_CTL    = 8'd97;
    localparam flat_t IX_SHADOW_CTL = 8'd98;
    localparam flat_t IX_EXC_CAUSE  = 8'd104;
    localparam flat_t IX_CPU_ID     = 8'd120;
    localparam flat_t IX_CFG0       = 8'd128;
    localparam flat_t IX_CFG1       = 8'd129;
    localparam flat_t IX_CFG2       = 8'd130;
    localparam flat_t IX_CFG3       = 8'd131;

    // Per-thread registers
    localparam flat_t IX_CORE_STAT   = 8'd96;
    localparam flat_t IX_THR_STAT    = 8'd17;
    localparam flat_t IX_THR_BIND    = 8'd18;
    localparam flat_t IX_THR_RESTART = 8'd19;
    localparam flat_t IX_THR_HALT    = 8'd20;
    localparam flat_t IX_THR_CTX     = 8'd21;
    localparam flat_t IX_THR_SCHED   = 8'd22;
    localparam flat_t IX_THR_SCHFB   = 8'd23;
    localparam flat_t IX_LINK_ADDR   = 8'd136;
    localparam flat_t IX_DBG_CTL     = 8'd184;

    // Per-virtual-processor registers
    localparam flat_t IX_VPR_CTL    = 8'd9;
    localparam flat_t IX_VPR_CONF0  = 8'd10;
    localparam flat_t IX_VPR_CONF1  = 8'd11;
    localparam flat_t IX_VPR_YIELD  = 8'd12;
    localparam flat_t IX_VPR_SCHED  = 8'd13;
    localparam flat_t IX_VPR_SCHFB  = 8'd14;
    localparam flat_t IX_VPR_OPT    = 8'd15;
    localparam flat_t IX_SHD_CONF0  = 8'd49;
    localparam flat_t IX_SHD_CONF1  = 8'd50;
    localparam flat_t IX_SHD_CONF2  = 8'd51;
    localparam flat_t IX_SHD_CONF3  = 8'd52;
    localparam flat_t IX_SHD_CONF4  = 8'd53;
    localparam flat_t IX_EXC_BASE   = 8'd121;

    localparam int N_SHARED = 16;
    localparam int N_THREAD = 10;
    localparam int N_VPROC  = 13;

    // Slot positions that other logic depends on
    localparam int TH_SLOT_STAT = 0;
    localparam int TH_SLOT_BIND = 2;

    localparam flat_t SHARED_MAP [N_SHARED] = '{
        IX_TLB_INDEX, IX_RAND, IX_TLB_LO0, IX_TLB_LO1,
        IX_PTE_CTX, IX_PG_MASK, IX_PG_GRAIN, IX_FAULT_VA,
        IX_IRQ_CTL, IX_SHADOW_CTL, IX_EXC_CAUSE, IX_CPU_ID,
        IX_CFG0, IX_CFG1, IX_CFG2, IX_CFG3
    };

    localparam flat_t THREAD_MAP [N_THREAD] = '{
        IX_CORE_STAT, IX_THR_STAT, IX_THR_BIND, IX_THR_RESTART,
        IX_THR_HALT, IX_THR_CTX, IX_THR_SCHED, IX_THR_SCHFB,
        IX_DBG_CTL, IX_LINK_ADDR
    };

    localparam flat_t VPROC_MAP [N_VPROC] = '{
        IX_VPR_CTL, IX_VPR_CONF0, IX_VPR_CONF1, IX_VPR_YIELD,
        IX_VPR_SCHED, IX_VPR_SCHFB, IX_VPR_OPT, IX_SHD_CONF0,
        IX_SHD_CONF1, IX_SHD_CONF2, IX_SHD_CONF3, IX_SHD_CONF4,
        IX_EXC_BASE
    };

    // Reset-programmed write mask of each register (1 = software-writable)
    function automatic word_t write_mask(flat_t ix);
        case (ix)
            IX_CORE_STAT:  return 32'hFF78_FF17;
            IX_RAND:       return 32'h0000_0000;
            IX_CPU_ID:     return 32'h0000_0000;
            IX_CFG0:       return 32'h7FFF_0007;
            IX_CFG1:       return 32'h0000_0000;
            IX_CFG2:       return 32'h7000_F000;
            IX_CFG3:       return 32'h0000_0000;
            IX_EXC_BASE:   return 32'h3FFF_F000;
            IX_SHADOW_CTL: return 32'h0000_F3C0;
            IX_IRQ_CTL:    return 32'h0000_03E0;
            IX_PG_GRAIN:   return 32'h1000_0000;
            IX_TLB_INDEX:  return 32'h7FFF_FFFF;
            IX_TLB_LO0:    return 32'h3FFF_FFFF;
            IX_TLB_LO1:    return 32'h3FFF_FFFF;
            IX_PTE_CTX:    return 32'hFF80_0000;
            IX_PG_MASK:    return 32'h1FFF_F800;
            IX_EXC_CAUSE:  return 32'h08C0_0300;
            IX_FAULT_VA:   return 32'h0000_0000;
            IX_LINK_ADDR:  return 32'h0000_0000;
            default:       return '1;
        endcase
    endfunction

endpackage

// File: rtl/crf_decode.sv
// Flat-index decoder: maps {reg, sel} to a storage class and a slot
// number within that class. Assumes the index maps in crf_pkg are
// free of duplicates. Purely combinational.
module crf_decode
    import crf_pkg::*;
(
    input  flat_t              ix,
    output kind_e              kind,
    output logic [SLOT_W-1:0]  slot
);

    // Search the three class maps for the index
    always_comb begin
        kind = K_NONE;
        slot = '0;
        for (int i = 0; i < N_SHARED; i++) begin
            if (ix == SHARED_MAP[i]) begin
                kind = K_SHARED;
                slot = SLOT_W'(i);
            end
        end
        for (int i = 0; i < N_THREAD; i++) begin
            if (ix == THREAD_MAP[i]) begin
                kind = K_THREAD;
                slot = SLOT_W'(i);
            end
        end
        for (int i = 0; i < N_VPROC; i++) begin
            if (ix == VPROC_MAP[i]) begin
                kind = K_VPROC;
                slot = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/crf_bank_sel.sv
// Virtual-processor bank selector: picks the bank field of the
// requesting thread's binding register. Assumes VP_W <= 4 (the field
// width); an out-of-range bank value falls back to bank 0.
module crf_bank_sel
    import crf_pkg::*;
#(
    parameter int NUM_TC    = 4,
    parameter int NUM_VPROC = 2,
    localparam int TID_W    = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
    localparam int VP_W     = (NUM_VPROC > 1) ? $clog2(NUM_VPROC) : 1
)(
    input  logic [TID_W-1:0]            tid,
    input  logic [NUM_TC-1:0][XLEN-1:0] bind_q,
    output logic [VP_W-1:0]             vproc
);

    logic [VP_W-1:0] field;

    // Fetch the bank field of the addressed thread, then range-check it
    always_comb begin
        field = '0;
        for (int t = 0; t < NUM_TC; t++) begin
            if (tid == TID_W'(t)) begin
                field = bind_q[t][VP_W-1:0];
            end
        end
        vproc = ({1'b0, field} < (VP_W+1)'(NUM_VPROC)) ? field : '0;
    end

endmodule

// File: rtl/crf_entry.sv
// One control register with a constant write mask. A direct write
// loads all bits; a software write merges under the mask. Assumes the
// parent has already decoded both enables to this copy.
module crf_entry
    import crf_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t WMASK   = '1
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sw_we,
    input  word_t sw_data,
    input  logic  hw_we,
    input  word_t hw_data,
    output word_t q
);

    // Register update: reset, then direct write, then masked write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (hw_we) begin
            q <= hw_data;
        end else if (sw_we) begin
            q <= (sw_data & WMASK) | (q & ~WMASK);
        end
    end

endmodule

// File: rtl/cp_ctrl_regfile.sv
// Banked control register file with per-register write masks.
// Shared registers have one copy, per-thread registers one per thread
// context, per-virtual-processor registers one per virtual processor
// (bank from the requester's binding register). Reads are
// combinational; writes land at the clock edge. Assumes NUM_TC and
// NUM_VPROC are at most 16 each.
module cp_ctrl_regfile
    import crf_pkg::*;
#(
    parameter int    NUM_TC    = 4,
    parameter int    NUM_VPROC = 2,
    parameter word_t PROC_ID   = 32'h0001_9500,
    parameter word_t CFG0_INIT = 32'h0000_0483,
    parameter word_t CFG1_INIT = 32'h9E19_0C8F,
    parameter word_t CFG2_INIT = 32'h8000_0000,
    parameter word_t CFG3_INIT = 32'h0000_0020,
    localparam int   TID_W     = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
    localparam int   VP_W      = (NUM_VPROC > 1) ? $clog2(NUM_VPROC) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TID_W-1:0] rd_tid,
    input  logic [4:0]       rd_reg,
    input  logic [2:0]       rd_sel,
    output logic [XLEN-1:0]  rd_data,
    input  logic             sw_we,
    input  logic [TID_W-1:0] sw_tid,
    input  logic [4:0]       sw_reg,
    input  logic [2:0]       sw_sel,
    input  logic [XLEN-1:0]  sw_data,
    input  logic             hw_we,
    input  logic [TID_W-1:0] hw_tid,
    input  logic [4:0]       hw_reg,
    input  logic [2:0]       hw_sel,
    input  logic [XLEN-1:0]  hw_data
);

    // Reset value of a shared register
    function automatic word_t shared_reset(flat_t ix);
        case (ix)
            IX_RAND:   return 32'd63;
            IX_CPU_ID: return PROC_ID;
            IX_CFG0:   return CFG0_INIT | 32'h8000_0000;
            IX_CFG1:   return CFG1_INIT;
            IX_CFG2:   return CFG2_INIT;
            IX_CFG3:   return CFG3_INIT;
            default:   return '0;
        endcase
    endfunction

    // Reset value of one thread's copy of a per-thread register
    function automatic word_t thread_reset(flat_t ix, int t);
        case (ix)
            IX_CORE_STAT: return 32'h0040_0004;
            IX_THR_STAT:  return (t == 0) ? 32'h0000_2000 : 32'h0000_8000;
            IX_THR_BIND:  return word_t'(t) << 21;
            default:      return '0;
        endcase
    endfunction

    // Reset value of one virtual processor's copy
    function automatic word_t vproc_reset(flat_t ix, int v);
        if (ix == IX_EXC_BASE) return 32'h8000_0000 | word_t'(v);
        return '0;
    endfunction

    flat_t              rd_ix, sw_ix, hw_ix;
    kind_e              rd_kind, sw_kind, hw_kind;
    logic [SLOT_W-1:0]  rd_slot, sw_slot, hw_slot;
    logic [VP_W-1:0]    rd_vp, sw_vp, hw_vp;

    logic [N_SHARED-1:0][XLEN-1:0]               sh_q;
    logic [NUM_TC-1:0][N_THREAD-1:0][XLEN-1:0]   th_q;
    logic [NUM_VPROC-1:0][N_VPROC-1:0][XLEN-1:0] vp_q;
    logic [NUM_TC-1:0][XLEN-1:0]                 bind_q;

    assign rd_ix = {rd_reg, rd_sel};
    assign sw_ix = {sw_reg, sw_sel};
    assign hw_ix = {hw_reg, hw_sel};

    crf_decode u_dec_rd (.ix(rd_ix), .kind(rd_kind), .slot(rd_slot));
    crf_decode u_dec_sw (.ix(sw_ix), .kind(sw_kind), .slot(sw_slot));
    crf_decode u_dec_hw (.ix(hw_ix), .kind(hw_kind), .slot(hw_slot));

    for (genvar t = 0; t < NUM_TC; t++) begin : g_bind
        assign bind_q[t] = th_q[t][TH_SLOT_BIND];
    end

    crf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPROC(NUM_VPROC)) u_bank_rd (
        .tid(rd_tid), .bind_q(bind_q), .vproc(rd_vp));
    crf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPROC(NUM_VPROC)) u_bank_sw (
        .tid(sw_tid), .bind_q(bind_q), .vproc(sw_vp));
    crf_bank_sel #(.NUM_TC(NUM_TC), .NUM_VPROC(NUM_VPROC)) u_bank_hw (
        .tid(hw_tid), .bind_q(bind_q), .vproc(hw_vp));

    // Shared registers: one copy each
    for (genvar s = 0; s < N_SHARED; s++) begin : g_sh
        crf_entry #(
            .RST_VAL(shared_reset(SHARED_MAP[s])),
            .WMASK  (write_mask(SHARED_MAP[s]))
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_we  (sw_we && sw_kind == K_SHARED && sw_slot == SLOT_W'(s)),
            .sw_data(sw_data),
            .hw_we  (hw_we && hw_kind == K_SHARED && hw_slot == SLOT_W'(s)),
            .hw_data(hw_data),
            .q      (sh_q[s])
        );
    end

    // Per-thread registers: one copy per thread context
    for (genvar t = 0; t < NUM_TC; t++) begin : g_th
        for (genvar s = 0; s < N_THREAD; s++) begin : g_slot
            crf_entry #(
                .RST_VAL(thread_reset(THREAD_MAP[s], t)),
                .WMASK  (write_mask(THREAD_MAP[s]))
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_we  (sw_we && sw_kind == K_THREAD &&
                         sw_slot == SLOT_W'(s) && sw_tid == TID_W'(t)),
                .sw_data(sw_data),
                .hw_we  (hw_we && hw_kind == K_THREAD &&
                         hw_slot == SLOT_W'(s) && hw_tid == TID_W'(t)),
                .hw_data(hw_data),
                .q      (th_q[t][s])
            );
        end
    end

    // Per-virtual-processor registers: one copy per virtual processor
    for (genvar v = 0; v < NUM_VPROC; v++) begin : g_vp
        for (genvar s = 0; s < N_VPROC; s++) begin : g_slot
            crf_entry #(
                .RST_VAL(vproc_reset(VPROC_MAP[s], v)),
                .WMASK  (write_mask(VPROC_MAP[s]))
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_we  (sw_we && sw_kind == K_VPROC &&
                         sw_slot == SLOT_W'(s) && sw_vp == VP_W'(v)),
                .sw_data(sw_data),
                .hw_we  (hw_we && hw_kind == K_VPROC &&
                         hw_slot == SLOT_W'(s) && hw_vp == VP_W'(v)),
                .hw_data(hw_data),
                .q      (vp_q[v][s])
            );
        end
    end

    // Read mux: select the addressed copy, zero for unimplemented indices
    always_comb begin
        rd_data = '0;
        case (rd_kind)
            K_SHARED: begin
                for (int s = 0; s < N_SHARED; s++) begin
                    if (rd_slot == SLOT_W'(s)) rd_data = sh_q[s];
                end
            end
            K_THREAD: begin
                for (int t = 0; t < NUM_TC; t++) begin
                    for (int s = 0; s < N_THREAD; s++) begin
                        if (rd_tid == TID_W'(t) && rd_slot == SLOT_W'(s))
                            rd_data = th_q[t][s];
                    end
                end
            end
            K_VPROC: begin
                for (int v = 0; v < NUM_VPROC; v++) begin
                    for (int s = 0; s < N_VPROC; s++) begin
                        if (rd_vp == VP_W'(v) && rd_slot == SLOT_W'(s))
                            rd_data = vp_q[v][s];
                    end
                end
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/crf_checker.sv
// Property checker for cp_ctrl_regfile, attached by bind. Watches the
// write ports, the read port and selected register copies.
module crf_checker
    import crf_pkg::*;
#(
    parameter int  NUM_TC = 4,
    localparam int TID_W  = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
)(
    input logic                               clk,
    input logic                               rst_n,
    input logic                               sw_we,
    input logic [TID_W-1:0]                   sw_tid,
    input logic [7:0]                         sw_ix,
    input logic [XLEN-1:0]                    sw_data,
    input logic                               hw_we,
    input logic [TID_W-1:0]                   hw_tid,
    input logic [7:0]                         hw_ix,
    input logic [XLEN-1:0]                    hw_data,
    input logic [7:0]                         rd_ix,
    input logic [XLEN-1:0]                    rd_data,
    input logic [XLEN-1:0]                    rand_q,
    input logic [XLEN-1:0]                    prid_q,
    input logic [NUM_TC-1:0][N_THREAD-1:0][XLEN-1:0] th_q
);

    localparam logic [XLEN-1:0] STAT_MASK = 32'hFF78_FF17;
    localparam logic [XLEN-1:0] STAT_RST  = 32'h0040_0004;

    for (genvar t = 0; t < NUM_TC; t++) begin : g_t
        p_stat_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> th_q[t][TH_SLOT_STAT] == STAT_RST);

        p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_we && !hw_we && sw_ix == IX_CORE_STAT && sw_tid == TID_W'(t))
            |=> th_q[t][TH_SLOT_STAT] ==
                (($past(sw_data) & STAT_MASK) |
                 ($past(th_q[t][TH_SLOT_STAT]) & ~STAT_MASK)));

        p_thread_isolation_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!(sw_we && sw_ix == IX_CORE_STAT && sw_tid == TID_W'(t)) &&
             !(hw_we && hw_ix == IX_CORE_STAT && hw_tid == TID_W'(t)))
            |=> $stable(th_q[t][TH_SLOT_STAT]));
    end

    p_rand_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_we && hw_ix == IX_RAND) |=> $stable(rand_q));

    p_prid_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_we && hw_ix == IX_CPU_ID) |=> $stable(prid_q));

    p_direct_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && hw_ix == IX_RAND) |=> rand_q == $past(hw_data));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ix == 8'd7) |-> rd_data == '0);

endmodule

bind cp_ctrl_regfile crf_checker #(.NUM_TC(NUM_TC)) u_crf_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_we  (sw_we),
    .sw_tid (sw_tid),
    .sw_ix  (sw_ix),
    .sw_data(sw_data),
    .hw_we  (hw_we),
    .hw_tid (hw_tid),
    .hw_ix  (hw_ix),
    .hw_data(hw_data),
    .rd_ix  (rd_ix),
    .rd_data(rd_data),
    .rand_q (sh_q[1]),
    .prid_q (sh_q[11]),
    .th_q   (th_q)
);

// File: tb/test_cp_ctrl_regfile.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read data, a monitor
// pops and compares it on the falling edge of the same cycle.
module test_cp_ctrl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rd_tid = '0, sw_tid = '0, hw_tid = '0;
    logic [4:0]  rd_reg = '0, sw_reg = '0, hw_reg = '0;
    logic [2:0]  rd_sel = '0, sw_sel = '0, hw_sel = '0;
    logic [31:0] rd_data, sw_data = '0, hw_data = '0;
    logic        sw_we = 1'b0, hw_we = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cp_ctrl_regfile i_cp_ctrl_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_tid(rd_tid), .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data),
        .sw_we(sw_we), .sw_tid(sw_tid), .sw_reg(sw_reg), .sw_sel(sw_sel), .sw_data(sw_data),
        .hw_we(hw_we), .hw_tid(hw_tid), .hw_reg(hw_reg), .hw_sel(hw_sel), .hw_data(hw_data)
    );

    // Monitor: compare one queued expectation per cycle at the falling edge
    logic [31:0] m_exp;
    string       m_tag;
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            m_exp = exp_q.pop_front();
            m_tag = tag_q.pop_front();
            checks++;
            if (rd_data !== m_exp) begin
                fails++;
                $display("FAIL %s: actual %08h expected %08h", m_tag, rd_data, m_exp);
            end
        end
    end

    task automatic sw_write(input logic [1:0] t, input logic [4:0] r,
                            input logic [2:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        sw_we = 1'b1; sw_tid = t; sw_reg = r; sw_sel = s; sw_data = d;
        @(posedge clk); #1;
        sw_we = 1'b0;
    endtask

    task automatic hw_write(input logic [1:0] t, input logic [4:0] r,
                            input logic [2:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        hw_we = 1'b1; hw_tid = t; hw_reg = r; hw_sel = s; hw_data = d;
        @(posedge clk); #1;
        hw_we = 1'b0;
    endtask

    task automatic both_write(input logic [4:0] r, input logic [2:0] s,
                              input logic [31:0] dsw, input logic [31:0] dhw);
        @(posedge clk); #1;
        sw_we = 1'b1; sw_tid = 2'd0; sw_reg = r; sw_sel = s; sw_data = dsw;
        hw_we = 1'b1; hw_tid = 2'd0; hw_reg = r; hw_sel = s; hw_data = dhw;
        @(posedge clk); #1;
        sw_we = 1'b0; hw_we = 1'b0;
    endtask

    // Driver: present a read address and queue what it must return
    task automatic check_rd(input logic [1:0] t, input logic [4:0] r,
                            input logic [2:0] s, input logic [31:0] e,
                            input string tag);
        @(posedge clk); #1;
        rd_tid = t; rd_reg = r; rd_sel = s;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        check_rd(2'd0, 5'd12, 3'd0, 32'h0040_0004, "R5 status thread0 reset");
        check_rd(2'd3, 5'd12, 3'd0, 32'h0040_0004, "R5 status thread3 reset");
        check_rd(2'd0, 5'd1,  3'd0, 32'd63,        "R6 random reset");
        check_rd(2'd0, 5'd15, 3'd0, 32'h0001_9500, "R6 cpu id reset");
        check_rd(2'd0, 5'd16, 3'd0, 32'h8000_0483, "R7 config0 reset");
        check_rd(2'd0, 5'd15, 3'd1, 32'h8000_0000, "R12 exc base vproc0 reset");
        check_rd(2'd2, 5'd2,  3'd2, 32'h0040_0000, "R4 bind thread2 reset");
        check_rd(2'd0, 5'd2,  3'd1, 32'h0000_2000, "R13 thread status t0 reset");
        check_rd(2'd1, 5'd2,  3'd1, 32'h0000_8000, "R13 thread status t1 reset");
        check_rd(2'd0, 5'd0,  3'd0, 32'h0000_0000, "R8 index reset");

        // Masked writes to the per-thread status register
        sw_write(2'd1, 5'd12, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd1, 5'd12, 3'd0, 32'hFF78_FF17, "R2 status ones (R11 same-cycle read)");
        check_rd(2'd0, 5'd12, 3'd0, 32'h0040_0004, "R3 other thread untouched");
        sw_write(2'd1, 5'd12, 3'd0, 32'h0000_0000);
        check_rd(2'd1, 5'd12, 3'd0, 32'h0000_0000, "R2 status zeros");

        // Fully writable register
        sw_write(2'd1, 5'd2, 3'd5, 32'hFFFF_FFFF);
        check_rd(2'd1, 5'd2, 3'd5, 32'hFFFF_FFFF, "R8 thread context writable");

        // Read-only registers and the direct port
        sw_write(2'd0, 5'd1, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd1, 3'd0, 32'd63, "R6 random ignores software write");
        hw_write(2'd0, 5'd1, 3'd0, 32'd5);
        check_rd(2'd0, 5'd1, 3'd0, 32'd5, "R9 random direct write");
        sw_write(2'd0, 5'd15, 3'd0, 32'h0000_0000);
        check_rd(2'd0, 5'd15, 3'd0, 32'h0001_9500, "R6 cpu id read-only");
        sw_write(2'd0, 5'd16, 3'd1, 32'h0000_0000);
        check_rd(2'd0, 5'd16, 3'd1, 32'h9E19_0C8F, "R6 config1 read-only");
        sw_write(2'd0, 5'd17, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd17, 3'd0, 32'h0000_0000, "R6 link address read-only");
        sw_write(2'd0, 5'd8, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd8, 3'd0, 32'h0000_0000, "R6 fault address read-only");
        hw_write(2'd0, 5'd8, 3'd0, 32'hDEAD_BEEF);
        check_rd(2'd0, 5'd8, 3'd0, 32'hDEAD_BEEF, "R9 fault address direct write");

        // Register-specific masks
        sw_write(2'd0, 5'd16, 3'd0, 32'h0000_0000);
        check_rd(2'd0, 5'd16, 3'd0, 32'h8000_0480, "R7 config0 zeros");
        sw_write(2'd0, 5'd16, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd16, 3'd0, 32'hFFFF_0487, "R7 config0 ones");
        sw_write(2'd0, 5'd16, 3'd2, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd16, 3'd2, 32'hF000_F000, "R7 config2 ones");
        sw_write(2'd0, 5'd13, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd13, 3'd0, 32'h08C0_0300, "R7 cause ones");
        sw_write(2'd0, 5'd2, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd2, 3'd0, 32'h3FFF_FFFF, "R7 tlb lo0 ones");
        sw_write(2'd0, 5'd3, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd3, 3'd0, 32'h3FFF_FFFF, "R7 tlb lo1 ones");
        sw_write(2'd0, 5'd4, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd4, 3'd0, 32'hFF80_0000, "R7 pte context ones");
        sw_write(2'd0, 5'd5, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd5, 3'd0, 32'h1FFF_F800, "R7 page mask ones");
        sw_write(2'd0, 5'd5, 3'd1, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd5, 3'd1, 32'h1000_0000, "R7 page grain ones");
        sw_write(2'd0, 5'd12, 3'd1, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd12, 3'd1, 32'h0000_03E0, "R7 irq ctl ones");
        sw_write(2'd0, 5'd12, 3'd2, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd12, 3'd2, 32'h0000_F3C0, "R7 shadow ctl ones");
        sw_write(2'd0, 5'd0, 3'd0, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd0, 3'd0, 32'h7FFF_FFFF, "R7 index ones");
        sw_write(2'd0, 5'd15, 3'd1, 32'hFFFF_FFFF);
        check_rd(2'd0, 5'd15, 3'd1, 32'hBFFF_F000, "R7 exc base ones");

        // Port collision: direct write wins
        both_write(5'd0, 3'd0, 32'hAAAA_AAAA, 32'h0000_0055);
        check_rd(2'd0, 5'd0, 3'd0, 32'h0000_0055, "R9 direct wins collision");

        // Unimplemented indices
        sw_write(2'd0, 5'd0, 3'd7, 32'hFFFF_FFFF);
        hw_write(2'd0, 5'd31, 3'd7, 32'h0000_FFFF);
        check_rd(2'd0, 5'd0,  3'd7, 32'h0000_0000, "R10 unmapped reads zero");
        check_rd(2'd0, 5'd31, 3'd7, 32'h0000_0000, "R10 unmapped direct write ignored");
        check_rd(2'd0, 5'd0,  3'd0, 32'h0000_0055, "R10 neighbour untouched");

        // Flat index decomposition
        sw_write(2'd0, 5'd2, 3'd3, 32'h0000_0077);
        check_rd(2'd0, 5'd2, 3'd3, 32'h0000_0077, "R1 reg2 sel3 written");
        check_rd(2'd0, 5'd3, 3'd2, 32'h0000_0000, "R1 reg3 sel2 distinct");

        // Virtual-processor banking through the binding register
        sw_write(2'd0, 5'd1, 3'd1, 32'h0000_1234);
        check_rd(2'd1, 5'd1, 3'd1, 32'h0000_1234, "R4 shared bank before rebind");
        sw_write(2'd1, 5'd2, 3'd2, 32'h0020_0001);
        check_rd(2'd1, 5'd2, 3'd2, 32'h0020_0001, "R4 bind writable");
        check_rd(2'd1, 5'd1, 3'd1, 32'h0000_0000, "R4 thread1 sees bank1");
        sw_write(2'd1, 5'd1, 3'd1, 32'h0000_ABCD);
        check_rd(2'd1, 5'd1, 3'd1, 32'h0000_ABCD, "R4 bank1 written");
        check_rd(2'd0, 5'd1, 3'd1, 32'h0000_1234, "R4 bank0 kept");
        check_rd(2'd1, 5'd15, 3'd1, 32'h8000_0001, "R12 exc base vproc1 reset");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule